// File: doc/BRIEF.md
# Packet Transmit Sequencer with Underflow Detection

This block drives one outgoing packet at a time. When the host issues a start command, it takes the packet length and pulls that many payload bytes from a transmit FIFO. It hands each byte to a serializer over a valid/ready handshake. It then sends the check bytes held by an external CRC unit, which it clears at packet start and feeds with every accepted payload byte. The length counts payload bytes only. Neither the preamble nor the CRC is counted. The CRC arithmetic and the line modulation belong to other blocks.

A packet can end in three ways, and each one produces the same single-cycle completion pulse:
- the last CRC byte is accepted;
- the host switches to receive mode while the packet is in flight;
- the sequencer needs another payload byte and finds the FIFO empty.

The third case also sets a sticky underflow flag, which only the host can clear. While a packet is active, an almost-empty event is raised once each time the FIFO fill level drops to a threshold. A select input chooses a threshold of 4 or 8 bytes. After any ending the sequencer goes idle and does not touch the FIFO until the next start.

Top module: `tx_pkt_sequencer`

## Requirements
- R1: After reset, `ser_valid`, `fifo_rd`, `tx_busy`, `tx_done`, `uf_flag`, `ae_evt` and `crc_clr` are all 0.
- R2: A start is accepted only when the block is idle and `rx_mode` is 0. When accepted, it captures `pkt_len`. A start given while busy, or while `rx_mode` is 1, has no effect.
- R3: The block reads exactly `pkt_len` payload bytes from the FIFO, in FIFO order. It asserts `fifo_rd` only when `fifo_count` is nonzero. Each byte stays on `ser_data` with `ser_valid` high until `ser_ready` accepts it.
- R4: After the payload come `CRC_BYTES` bytes from `crc_value`, most significant byte first. `crc_clr` pulses once per accepted start. `crc_en` pulses once per accepted payload byte.
- R5: `tx_done` is a one-cycle pulse that follows the acceptance of the last CRC byte. `tx_busy` is 0 while `tx_done` is 1.
- R6: If `rx_mode` is 1 while busy, the packet ends on the next clock edge: `tx_done` pulses, `tx_busy` and `ser_valid` drop, and `uf_flag` keeps its value.
- R7: If payload bytes remain, no byte is pending, and `fifo_count` is 0, the packet ends. `tx_done` pulses, `uf_flag` is set, and no CRC byte is sent.
- R8: `uf_flag` stays at 1 through later normal and aborted packets. It returns to 0 only on an `uf_clr` pulse.
- R9: `ae_evt` pulses once while busy, one cycle after `fifo_count` drops from above the threshold to at or below it. The threshold is 4 when `ae_sel` is 0 and 8 when `ae_sel` is 1. No pulse occurs while idle.
- R10: After any ending the block makes no FIFO read and sends no byte until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start command for one packet |
| rx_mode | input | 1 | Host receive-mode request; aborts an active packet |
| pkt_len | input | LEN_W | Payload length in bytes, excluding CRC |
| ae_sel | input | 1 | Almost-empty threshold select (0: 4 bytes, 1: 8 bytes) |
| uf_clr | input | 1 | Clears the sticky underflow flag |
| fifo_count | input | CNT_W | Bytes currently in the transmit FIFO |
| fifo_data | input | DATA_W | Head byte of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pops the FIFO head |
| crc_value | input | DATA_W*CRC_BYTES | Running CRC from the external CRC unit |
| crc_clr | output | 1 | Clears the CRC unit at packet start |
| crc_en | output | 1 | Marks an accepted payload byte on `ser_data` for the CRC unit |
| ser_data | output | DATA_W | Byte offered to the serializer |
| ser_valid | output | 1 | `ser_data` holds a byte |
| ser_ready | input | 1 | Serializer takes the byte |
| tx_busy | output | 1 | A packet is in progress |
| tx_done | output | 1 | One-cycle transmit-finished pulse |
| uf_flag | output | 1 | Sticky underflow status |
| ae_evt | output | 1 | One-cycle FIFO almost-empty event |

## Verification
The bench sweeps every payload length from 0 to 16 across both thresholds and two serializer pacing patterns. It predicts the exact byte stream and the number of almost-empty pulses, which is one only when the length exceeds the threshold. A design that compared with the wrong sense at the boundary length, or that fired on a level rather than a crossing, would show a pulse count off by one or many. Underflow is forced with a short FIFO. A design that went on to the CRC, or left the flag clear, would emit extra bytes or miss the status. The flag is then carried through normal and aborted packets, which exposes a flag cleared by any ending. The bench also checks:
- that an aborted or finished sequencer no longer reads the FIFO, since one that kept reading would drain bytes the host still owns;
- that start is ignored while busy or in receive mode, since a design that honoured it would restart or lengthen the packet.

// File: rtl/tx_seq_pkg.sv
package tx_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_PAYLOAD = 2'd1,
      ST_CRC     = 2'd2
   } seq_state_t;

   typedef enum logic [1:0] {
      END_NONE      = 2'd0,
      END_NORMAL    = 2'd1,
      END_ABORT     = 2'd2,
      END_UNDERFLOW = 2'd3
   } end_kind_t;

endpackage

// File: rtl/tx_seq_crc_pick.sv
// Selects one CRC byte by index; a parameter picks the byte order.
module tx_seq_crc_pick #(
   parameter int DATA_W    = 8,
   parameter int CRC_BYTES = 2,
   parameter bit MSB_FIRST = 1'b1,
   parameter int IDX_W     = 2
) (
   input  logic [DATA_W*CRC_BYTES-1:0] crc_value,
   input  logic [IDX_W-1:0]            idx,
   output logic [DATA_W-1:0]           byte_out
);

   generate
      if (MSB_FIRST) begin : g_msb
         always_comb begin
            byte_out = '0;
            for (int k = 0; k < CRC_BYTES; k++) begin
               if (idx == IDX_W'(k))
                  byte_out = crc_value[(CRC_BYTES-1-k)*DATA_W +: DATA_W];
            end
         end
      end else begin : g_lsb
         always_comb begin
            byte_out = '0;
            for (int k = 0; k < CRC_BYTES; k++) begin
               if (idx == IDX_W'(k))
                  byte_out = crc_value[k*DATA_W +: DATA_W];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tx_seq_ctrl.sv
// Packet state machine with a single-entry holding register toward the serializer.
module tx_seq_ctrl
   import tx_seq_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LEN_W     = 8,
   parameter int CNT_W     = 5,
   parameter int CRC_BYTES = 2,
   parameter int IDX_W     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rx_mode,
   input  logic [LEN_W-1:0]  pkt_len,
   input  logic [CNT_W-1:0]  fifo_count,
   input  logic [DATA_W-1:0] fifo_data,
   output logic              fifo_rd,
   input  logic [DATA_W-1:0] crc_byte,
   output logic [IDX_W-1:0]  crc_idx,
   output logic              crc_clr,
   output logic              crc_en,
   output logic [DATA_W-1:0] ser_data,
   output logic              ser_valid,
   input  logic              ser_ready,
   output logic              busy,
   output end_kind_t         end_kind
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CRC_BYTES);

   seq_state_t        st_q, st_d;
   logic [LEN_W-1:0]  remain_q;
   logic [IDX_W-1:0]  idx_q;
   logic [DATA_W-1:0] hold_q;
   logic              hold_v_q;
   logic              clr_q, clr_d;
   logic              load_fifo, load_crc;
   logic              accept;
   logic              fifo_empty;

   assign accept     = hold_v_q & ser_ready;
   assign fifo_empty = (fifo_count == '0);

   always_comb begin
      st_d      = st_q;
      clr_d     = 1'b0;
      load_fifo = 1'b0;
      load_crc  = 1'b0;
      end_kind  = END_NONE;
      unique case (st_q)
         ST_IDLE: begin
            if (start && !rx_mode) begin
               st_d  = ST_PAYLOAD;
               clr_d = 1'b1;
            end
         end
         ST_PAYLOAD: begin
            if (rx_mode) begin
               st_d     = ST_IDLE;
               end_kind = END_ABORT;
            end else if (!hold_v_q) begin
               if (remain_q == '0) begin
                  st_d = ST_CRC;
               end else if (fifo_empty) begin
                  st_d     = ST_IDLE;
                  end_kind = END_UNDERFLOW;
               end else begin
                  load_fifo = 1'b1;
               end
            end
         end
         ST_CRC: begin
            if (rx_mode) begin
               st_d     = ST_IDLE;
               end_kind = END_ABORT;
            end else if (!hold_v_q) begin
               if (idx_q == LAST_IDX) begin
                  st_d     = ST_IDLE;
                  end_kind = END_NORMAL;
               end else begin
                  load_crc = 1'b1;
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         remain_q <= '0;
         idx_q    <= '0;
         hold_q   <= '0;
         hold_v_q <= 1'b0;
         clr_q    <= 1'b0;
      end else begin
         st_q  <= st_d;
         clr_q <= clr_d;
         if (clr_d) begin
            remain_q <= pkt_len;
            idx_q    <= '0;
         end
         if (load_fifo) begin
            hold_q   <= fifo_data;
            hold_v_q <= 1'b1;
            remain_q <= remain_q - 1'b1;
         end else if (load_crc) begin
            hold_q   <= crc_byte;
            hold_v_q <= 1'b1;
            idx_q    <= idx_q + 1'b1;
         end else if (accept || st_d == ST_IDLE) begin
            hold_v_q <= 1'b0;
         end
      end
   end

   assign fifo_rd   = load_fifo;
   assign crc_idx   = idx_q;
   assign crc_clr   = clr_q;
   assign crc_en    = accept & (st_q == ST_PAYLOAD);
   assign ser_data  = hold_q;
   assign ser_valid = hold_v_q;
   assign busy      = (st_q != ST_IDLE);

endmodule

// File: rtl/tx_seq_ae_det.sv
// Falling-crossing detector on the FIFO level against a selectable threshold.
module tx_seq_ae_det #(
   parameter int CNT_W = 5,
   parameter int AE_LO = 4,
   parameter int AE_HI = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic             ae_sel,
   input  logic [CNT_W-1:0] fifo_count,
   output logic             ae_evt
);

   localparam logic [CNT_W-1:0] THR_LO = CNT_W'(AE_LO);
   localparam logic [CNT_W-1:0] THR_HI = CNT_W'(AE_HI);

   logic [CNT_W-1:0] prev_q;
   logic [CNT_W-1:0] thr;
   logic             ae_q;

   assign thr = ae_sel ? THR_HI : THR_LO;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         ae_q   <= 1'b0;
      end else begin
         prev_q <= fifo_count;
         ae_q   <= busy && (prev_q > thr) && (fifo_count <= thr);
      end
   end

   assign ae_evt = ae_q;

endmodule

// File: rtl/tx_seq_end_report.sv
// Completion pulse and sticky underflow status.
module tx_seq_end_report
   import tx_seq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  end_kind_t end_kind,
   input  logic      uf_clr,
   output logic      tx_done,
   output logic      uf_flag
);

   logic done_q, uf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         uf_q   <= 1'b0;
      end else begin
         done_q <= (end_kind != END_NONE);
         if (end_kind == END_UNDERFLOW)
            uf_q <= 1'b1;
         else if (uf_clr)
            uf_q <= 1'b0;
      end
   end

   assign tx_done = done_q;
   assign uf_flag = uf_q;

endmodule

// File: rtl/tx_pkt_sequencer.sv
module tx_pkt_sequencer
   import tx_seq_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int LEN_W         = 8,
   parameter int CNT_W         = 5,
   parameter int CRC_BYTES     = 2,
   parameter bit CRC_MSB_FIRST = 1'b1,
   parameter int AE_LO         = 4,
   parameter int AE_HI         = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start,
   input  logic                        rx_mode,
   input  logic [LEN_W-1:0]            pkt_len,
   input  logic                        ae_sel,
   input  logic                        uf_clr,
   input  logic [CNT_W-1:0]            fifo_count,
   input  logic [DATA_W-1:0]           fifo_data,
   output logic                        fifo_rd,
   input  logic [DATA_W*CRC_BYTES-1:0] crc_value,
   output logic                        crc_clr,
   output logic                        crc_en,
   output logic [DATA_W-1:0]           ser_data,
   output logic                        ser_valid,
   input  logic                        ser_ready,
   output logic                        tx_busy,
   output logic                        tx_done,
   output logic                        uf_flag,
   output logic                        ae_evt
);

   localparam int IDX_W = $clog2(CRC_BYTES + 1);

   generate
      if (CRC_BYTES < 1) begin : g_bad_crc
         $error("CRC_BYTES must be at least 1");
      end
      if (AE_LO >= AE_HI) begin : g_bad_thr_order
         $error("AE_LO must be below AE_HI");
      end
      if (AE_HI >= (1 << CNT_W)) begin : g_bad_thr_range
         $error("AE_HI must fit in the FIFO count width");
      end
      if (DATA_W < 1 || LEN_W < 1) begin : g_bad_width
         $error("DATA_W and LEN_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]  crc_idx;
   logic [DATA_W-1:0] crc_byte;
   end_kind_t         end_kind;
   logic              busy;

   tx_seq_crc_pick #(
      .DATA_W   (DATA_W),
      .CRC_BYTES(CRC_BYTES),
      .MSB_FIRST(CRC_MSB_FIRST),
      .IDX_W    (IDX_W)
   ) u_pick (
      .crc_value(crc_value),
      .idx      (crc_idx),
      .byte_out (crc_byte)
   );

   tx_seq_ctrl #(
      .DATA_W   (DATA_W),
      .LEN_W    (LEN_W),
      .CNT_W    (CNT_W),
      .CRC_BYTES(CRC_BYTES),
      .IDX_W    (IDX_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rx_mode   (rx_mode),
      .pkt_len   (pkt_len),
      .fifo_count(fifo_count),
      .fifo_data (fifo_data),
      .fifo_rd   (fifo_rd),
      .crc_byte  (crc_byte),
      .crc_idx   (crc_idx),
      .crc_clr   (crc_clr),
      .crc_en    (crc_en),
      .ser_data  (ser_data),
      .ser_valid (ser_valid),
      .ser_ready (ser_ready),
      .busy      (busy),
      .end_kind  (end_kind)
   );

   tx_seq_ae_det #(
      .CNT_W(CNT_W),
      .AE_LO(AE_LO),
      .AE_HI(AE_HI)
   ) u_ae (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy),
      .ae_sel    (ae_sel),
      .fifo_count(fifo_count),
      .ae_evt    (ae_evt)
   );

   tx_seq_end_report u_end (
      .clk     (clk),
      .rst_n   (rst_n),
      .end_kind(end_kind),
      .uf_clr  (uf_clr),
      .tx_done (tx_done),
      .uf_flag (uf_flag)
   );

   assign tx_busy = busy;

endmodule

// File: rtl/tx_seq_checker.sv
module tx_seq_checker #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_mode,
   input logic              uf_clr,
   input logic [CNT_W-1:0]  fifo_count,
   input logic              fifo_rd,
   input logic [DATA_W-1:0] ser_data,
   input logic              ser_valid,
   input logic              ser_ready,
   input logic              tx_busy,
   input logic              tx_done,
   input logic              uf_flag,
   input logic              ae_evt
);

   assert_rd_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> (fifo_count != '0));

   assert_byte_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_valid && !ser_ready && !rx_mode) |=> (ser_valid && $stable(ser_data)));

   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> !tx_busy);

   assert_abort_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && rx_mode) |=> (!tx_busy && tx_done && !ser_valid));

   assert_uf_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uf_flag) |-> tx_done);

   assert_uf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_flag && !uf_clr) |=> uf_flag);

   assert_ae_in_packet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ae_evt |-> $past(tx_busy));

   assert_idle_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> !fifo_rd);

endmodule

bind tx_pkt_sequencer tx_seq_checker #(
   .DATA_W(DATA_W),
   .CNT_W (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_mode   (rx_mode),
   .uf_clr    (uf_clr),
   .fifo_count(fifo_count),
   .fifo_rd   (fifo_rd),
   .ser_data  (ser_data),
   .ser_valid (ser_valid),
   .ser_ready (ser_ready),
   .tx_busy   (tx_busy),
   .tx_done   (tx_done),
   .uf_flag   (uf_flag),
   .ae_evt    (ae_evt)
);

// File: tb/tb_tx_pkt_sequencer.sv
module tb_tx_pkt_sequencer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rx_mode = 1'b0;
   logic [7:0]  pkt_len = '0;
   logic        ae_sel = 1'b0;
   logic        uf_clr = 1'b0;
   logic [4:0]  fifo_count;
   logic [7:0]  fifo_data;
   logic        fifo_rd;
   logic [15:0] crc_value = 16'hC35A;
   logic        crc_clr, crc_en;
   logic [7:0]  ser_data;
   logic        ser_valid;
   logic        ser_ready = 1'b0;
   logic        tx_busy, tx_done, uf_flag, ae_evt;

   always #4 clk = ~clk;

   tx_pkt_sequencer dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode),
      .pkt_len(pkt_len), .ae_sel(ae_sel), .uf_clr(uf_clr),
      .fifo_count(fifo_count), .fifo_data(fifo_data), .fifo_rd(fifo_rd),
      .crc_value(crc_value), .crc_clr(crc_clr), .crc_en(crc_en),
      .ser_data(ser_data), .ser_valid(ser_valid), .ser_ready(ser_ready),
      .tx_busy(tx_busy), .tx_done(tx_done), .uf_flag(uf_flag), .ae_evt(ae_evt)
   );

   // FIFO model (show-ahead), event counters and byte log
   logic [7:0] mem [0:31];
   int wr_ptr = 0;
   int rd_ptr = 0;
   logic flush_req = 1'b0;
   logic [7:0] log_q [0:1023];
   int log_n = 0, done_n = 0, ae_n = 0, cen_n = 0, cclr_n = 0;

   assign fifo_count = 5'(wr_ptr - rd_ptr);
   assign fifo_data  = mem[rd_ptr[4:0]];

   always @(posedge clk) begin
      if (fifo_rd) rd_ptr <= rd_ptr + 1;
      else if (flush_req) rd_ptr <= wr_ptr;
      if (ser_valid && ser_ready) begin
         log_q[log_n[9:0]] <= ser_data;
         log_n <= log_n + 1;
      end
      if (tx_done) done_n <= done_n + 1;
      if (ae_evt)  ae_n   <= ae_n + 1;
      if (crc_en)  cen_n  <= cen_n + 1;
      if (crc_clr) cclr_n <= cclr_n + 1;
   end

   // Serializer pacing: mode 0 always ready, mode 1 ready one cycle in three
   int rdy_mode = 0;
   int cyc = 0;
   always @(negedge clk) begin
      cyc = cyc + 1;
      ser_ready = (rdy_mode == 0) || (cyc % 3 == 2);
   end

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   task automatic eq(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      mem[wr_ptr[4:0]] = b;
      wr_ptr++;
   endtask

   task automatic kick(input int len);
      start   = 1'b1;
      pkt_len = 8'(len);
      tick(1);
      start   = 1'b0;
   endtask

   task automatic wait_end(input int db);
      int g = 0;
      while (done_n == db && g < 20000) begin
         tick(1);
         g++;
      end
   endtask

   function automatic logic [7:0] pat(input int len, input int i);
      return 8'(len * 37 + i * 11 + 5);
   endfunction

   function automatic int prefix_bad(input int base, input int len, input int n);
      int bad = 0;
      for (int i = 0; i < n; i++)
         if (log_q[10'(base + i)] !== pat(len, i)) bad++;
      return bad;
   endfunction

   initial begin
      int lb, db, ab, cb, ccb, thr, cnt_snap, sent;
      tick(5);
      // R1 reset state
      eq("R1", "ser_valid", int'(ser_valid), 0);
      eq("R1", "fifo_rd",   int'(fifo_rd), 0);
      eq("R1", "tx_busy",   int'(tx_busy), 0);
      eq("R1", "tx_done",   int'(tx_done), 0);
      eq("R1", "uf_flag",   int'(uf_flag), 0);
      eq("R1", "ae_evt",    int'(ae_evt), 0);
      eq("R1", "crc_clr",   int'(crc_clr), 0);
      rst_n = 1'b1;
      tick(2);

      // Sweep of lengths 0..16, both thresholds, two pacings (R3 R4 R5 R9)
      for (int len = 0; len <= 16; len++) begin
         rdy_mode = len % 2;
         ae_sel   = ((len / 2) % 2) == 1;
         thr      = ae_sel ? 8 : 4;
         for (int i = 0; i < len; i++) push(pat(len, i));
         tick(1);
         lb = log_n; db = done_n; ab = ae_n; cb = cen_n; ccb = cclr_n;
         kick(len);
         wait_end(db);
         tick(3);
         eq("R3", "bytes sent", log_n - lb, len + 2);
         eq("R3", "payload mismatches", prefix_bad(lb, len, len), 0);
         eq("R4", "first crc byte",  int'(log_q[10'(lb + len)]), 'hC3);
         eq("R4", "second crc byte", int'(log_q[10'(lb + len + 1)]), 'h5A);
         eq("R4", "crc_en pulses", cen_n - cb, len);
         eq("R4", "crc_clr pulses", cclr_n - ccb, 1);
         eq("R5", "done pulses", done_n - db, 1);
         eq("R5", "busy after end", int'(tx_busy), 0);
         eq("R9", "almost-empty pulses", ae_n - ab, (len > thr) ? 1 : 0);
         eq("R7", "uf after normal end", int'(uf_flag), 0);
      end

      // R10 idle block leaves the FIFO alone
      rdy_mode = 0;
      lb = log_n; db = done_n;
      for (int i = 0; i < 5; i++) push(pat(5, i));
      tick(20);
      eq("R10", "fifo count while idle", int'(fifo_count), 5);
      eq("R10", "bytes sent while idle", log_n - lb, 0);

      // R2 start ignored while rx_mode is high
      rx_mode = 1'b1;
      kick(5);
      tick(10);
      eq("R2", "busy with rx_mode", int'(tx_busy), 0);
      eq("R2", "fifo count with rx_mode", int'(fifo_count), 5);
      eq("R2", "done with rx_mode", done_n - db, 0);
      rx_mode = 1'b0;
      tick(1);

      // R2 second start while busy is ignored
      rdy_mode = 1;
      lb = log_n; db = done_n;
      kick(5);
      tick(4);
      kick(9);
      wait_end(db);
      tick(3);
      eq("R2", "bytes with start while busy", log_n - lb, 7);
      eq("R2", "done with start while busy", done_n - db, 1);
      eq("R2", "fifo left", int'(fifo_count), 0);

      // R7 underflow
      rdy_mode = 0;
      ae_sel = 1'b0;
      for (int i = 0; i < 3; i++) push(pat(6, i));
      tick(1);
      lb = log_n; db = done_n; cb = cen_n;
      kick(6);
      wait_end(db);
      tick(3);
      eq("R7", "bytes before underflow", log_n - lb, 3);
      eq("R7", "underflow payload mismatches", prefix_bad(lb, 6, 3), 0);
      eq("R7", "uf_flag set", int'(uf_flag), 1);
      eq("R7", "done on underflow", done_n - db, 1);
      eq("R7", "crc_en on underflow", cen_n - cb, 3);
      eq("R7", "busy after underflow", int'(tx_busy), 0);

      // R8 flag survives a normal packet
      push(pat(2, 0)); push(pat(2, 1));
      tick(1);
      lb = log_n; db = done_n;
      kick(2);
      wait_end(db);
      tick(3);
      eq("R8", "bytes of normal packet", log_n - lb, 4);
      eq("R8", "uf kept after normal end", int'(uf_flag), 1);

      // R6 abort by receive mode
      rdy_mode = 1;
      for (int i = 0; i < 10; i++) push(pat(10, i));
      tick(1);
      lb = log_n; db = done_n;
      kick(10);
      begin
         int g = 0;
         while (log_n - lb < 3 && g < 500) begin tick(1); g++; end
      end
      rx_mode = 1'b1;
      tick(1);
      rx_mode = 1'b0;
      tick(2);
      sent = log_n - lb;
      eq("R6", "done on abort", done_n - db, 1);
      eq("R6", "busy after abort", int'(tx_busy), 0);
      eq("R6", "ser_valid after abort", int'(ser_valid), 0);
      eq("R8", "uf kept after abort", int'(uf_flag), 1);
      eq("R6", "sent bytes are payload", prefix_bad(lb, 10, sent), 0);
      eq("R6", "abort cut packet short", int'(sent < 10), 1);
      cnt_snap = int'(fifo_count);
      tick(20);
      eq("R10", "fifo count after abort", int'(fifo_count), cnt_snap);
      eq("R10", "bytes after abort", log_n - lb, sent);

      // R9 level falling while idle makes no event
      ab = ae_n;
      eq("R9", "fifo above threshold before flush", int'(fifo_count > 4), 1);
      flush_req = 1'b1;
      tick(1);
      flush_req = 1'b0;
      tick(3);
      eq("R9", "no event while idle", ae_n - ab, 0);

      // R8 host clear
      uf_clr = 1'b1;
      tick(1);
      uf_clr = 1'b0;
      tick(1);
      eq("R8", "uf cleared by host", int'(uf_flag), 0);

      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #1200000;
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule